// File: doc/BRIEF.md
# Chunk Commit Order Logger

This block sits next to the commit arbiter of a chunk-based multiprocessor. It watches every chunk commit and writes the two logs that a deterministic replay needs. A commit notification carries the identity of the committing agent, the number of instructions in the chunk and a flag that marks the chunk as cut short. The agent is one of the processors or the DMA engine. From these notifications the block builds two output streams. The first is an order stream that lists which agent committed, one entry per commit. The second is a size stream that lets replay rebuild where each processor's chunks ended.

The size stream has two encodings, chosen by a mode pin. In the per-chunk encoding every processor chunk yields an entry: a single zero bit for a full chunk, or a twelve-bit entry for a cut-short chunk. In the distance encoding, full chunks only advance a per-processor counter. A cut-short chunk then yields one wide entry that holds its instruction count and the number of full chunks since that processor's previous entry. A second mode pin declares that commits follow a fixed round-robin order, which replay can infer, so the order stream stays silent in that mode. Both output streams use valid/ready. When either stream cannot take an entry, the block holds off new commits instead of dropping them.

Top module: `chunk_order_log`

## Requirements
- R1: After reset, ord_valid and sz_valid are low and cmt_ready is high.
- R2: With cfg_rr_order low, every accepted commit yields exactly one order entry, in acceptance order. Its ord_id equals the committing agent number: processors are 0 to N_PROC-1 and the DMA agent is N_PROC (8 by default).
- R3: With cfg_rr_order high, accepted commits yield no order entries.
- R4: With cfg_dist_mode low, a processor commit with cmt_trunc low yields a size entry with sz_len = 1 and sz_data = 0.
- R5: With cfg_dist_mode low, a processor commit with cmt_trunc high yields a size entry with sz_len = SIZE_W+1. Bit SIZE_W of sz_data is 1, bits SIZE_W-1:0 hold cmt_count, and all higher bits are 0.
- R6: With cfg_dist_mode high, a full processor commit yields no size entry and adds one to that processor's full-chunk counter, unless R8 applies.
- R7: With cfg_dist_mode high, a cut-short processor commit yields an entry with sz_len = ENT_W. Bits SIZE_W+DIST_W-1:DIST_W hold cmt_count and bits DIST_W-1:0 hold that processor's full-chunk count. The counter of that processor alone is then cleared.
- R8: With cfg_dist_mode high, a full commit that would bring its processor's counter to 2^DIST_W-1 instead yields an entry with a zero count field and all-ones in the distance field, and then clears that counter.
- R9: DMA commits never yield size entries.
- R10: cmt_ready is low exactly when some stream holds an entry that its ready does not take. An entry that is not taken stays on its stream unchanged, and no entry is lost.
- R11: sz_proc carries the processor number of the commit that produced the size entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_dist_mode | input | 1 | 1 selects distance encoding, 0 selects per-chunk encoding |
| cfg_rr_order | input | 1 | 1 marks commit order as round-robin, so no order entries are made |
| cmt_valid | input | 1 | Commit notification present |
| cmt_ready | output | 1 | Block takes the notification this cycle |
| cmt_agent | input | ID_W (4) | Committing agent, N_PROC means DMA |
| cmt_count | input | SIZE_W (11) | Instructions in the chunk |
| cmt_trunc | input | 1 | Chunk was cut short of the maximum size |
| ord_valid | output | 1 | Order entry present |
| ord_ready | input | 1 | Order consumer takes the entry |
| ord_id | output | ID_W (4) | Agent number of the order entry |
| sz_valid | output | 1 | Size entry present |
| sz_ready | input | 1 | Size consumer takes the entry |
| sz_proc | output | PIDX_W (3) | Processor that the size entry belongs to |
| sz_len | output | LEN_W (6) | Number of meaningful low bits in sz_data |
| sz_data | output | ENT_W (32) | Size entry, right-aligned |

## Verification
The hardest situation to reach from the ports is the counter saturation of R8. With the default 21-bit distance it needs about two million full chunks from one processor. The bench therefore builds the block with a 4-bit distance field and then sends one processor a run of sixteen full chunks followed by a cut-short one. The saturation entry must appear on the fifteenth chunk, and the cut-short entry that follows must report a distance of one. A second hard case is a commit arriving while one stream is stalled and the other is draining. The bench reaches it by driving both ready inputs from independent pseudo-random patterns during long mixed runs.

// File: rtl/chunk_log_pkg.sv
package chunk_log_pkg;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   function automatic int bits_for(input int v);
      return (v <= 1) ? 1 : $clog2(v + 1);
   endfunction

endpackage

// File: rtl/clog_out_stage.sv
module clog_out_stage #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_data,
   output logic         free,
   output logic         out_valid,
   input  logic         out_ready,
   output logic [W-1:0] out_data
);

   assign free = !out_valid || out_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else if (free) begin
         out_valid <= load;
         if (load) out_data <= load_data;
      end
   end

   p_hold_stream_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)))
      else $error("stalled entry changed or vanished");

endmodule

// File: rtl/clog_dist_counters.sv
module clog_dist_counters #(
   parameter int N_PROC = 8,
   parameter int DIST_W = 21,
   localparam int IDX_W = (N_PROC > 1) ? $clog2(N_PROC) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  idx,
   output logic [DIST_W-1:0] cur,
   input  logic              we,
   input  logic [DIST_W-1:0] wval
);

   logic [DIST_W-1:0] ctr [N_PROC];

   for (genvar i = 0; i < N_PROC; i++) begin : g_ctr
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                        ctr[i] <= '0;
         else if (we && idx == IDX_W'(i))   ctr[i] <= wval;
      end

      p_ctr_below_top_r8: assert property (@(posedge clk) disable iff (!rst_n)
         ctr[i] != {DIST_W{1'b1}})
         else $error("distance counter reached saturation value");
   end

   assign cur = ctr[idx];

endmodule

// File: rtl/clog_size_encoder.sv
module clog_size_encoder #(
   parameter int SIZE_W = 11,
   parameter int DIST_W = 21,
   parameter int ENT_W  = 32,
   parameter int LEN_W  = 6
) (
   input  logic              dist_mode,
   input  logic              trunc,
   input  logic [SIZE_W-1:0] count,
   input  logic [DIST_W-1:0] ctr,
   output logic              emit,
   output logic [LEN_W-1:0]  len,
   output logic [ENT_W-1:0]  data,
   output logic              ctr_we,
   output logic [DIST_W-1:0] ctr_next
);

   localparam logic [DIST_W-1:0] DTOP = {DIST_W{1'b1}};

   logic [DIST_W-1:0] inc;
   assign inc = ctr + DIST_W'(1);

   always_comb begin
      emit     = 1'b0;
      len      = '0;
      data     = '0;
      ctr_we   = 1'b0;
      ctr_next = ctr;
      if (!dist_mode) begin
         emit = 1'b1;
         if (trunc) begin
            len  = LEN_W'(SIZE_W + 1);
            data = ENT_W'({1'b1, count});
         end else begin
            len  = LEN_W'(1);
         end
      end else if (trunc) begin
         emit     = 1'b1;
         len      = LEN_W'(ENT_W);
         data     = ENT_W'({count, ctr});
         ctr_we   = 1'b1;
         ctr_next = '0;
      end else if (inc == DTOP) begin
         emit     = 1'b1;
         len      = LEN_W'(ENT_W);
         data     = ENT_W'({{SIZE_W{1'b0}}, DTOP});
         ctr_we   = 1'b1;
         ctr_next = '0;
      end else begin
         ctr_we   = 1'b1;
         ctr_next = inc;
      end
   end

endmodule

// File: rtl/chunk_order_log.sv
module chunk_order_log
   import chunk_log_pkg::*;
#(
   parameter int N_PROC    = 8,
   parameter int ID_W      = 4,
   parameter int SIZE_W    = 11,
   parameter int DIST_W    = 21,
   localparam int PIDX_W   = (N_PROC > 1) ? $clog2(N_PROC) : 1,
   localparam int ENT_W    = imax(SIZE_W + DIST_W, SIZE_W + 1),
   localparam int LEN_W    = bits_for(ENT_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_dist_mode,
   input  logic              cfg_rr_order,
   input  logic              cmt_valid,
   output logic              cmt_ready,
   input  logic [ID_W-1:0]   cmt_agent,
   input  logic [SIZE_W-1:0] cmt_count,
   input  logic              cmt_trunc,
   output logic              ord_valid,
   input  logic              ord_ready,
   output logic [ID_W-1:0]   ord_id,
   output logic              sz_valid,
   input  logic              sz_ready,
   output logic [PIDX_W-1:0] sz_proc,
   output logic [LEN_W-1:0]  sz_len,
   output logic [ENT_W-1:0]  sz_data
);

   localparam int SZ_REC_W = PIDX_W + LEN_W + ENT_W;

   if (N_PROC + 1 > (1 << ID_W)) begin : g_bad_id
      $error("ID_W too narrow for processors plus DMA");
   end
   if (SIZE_W < 1 || DIST_W < 2) begin : g_bad_width
      $error("SIZE_W must be at least 1 and DIST_W at least 2");
   end

   logic accept, is_dma, ord_free, sz_free;
   logic [PIDX_W-1:0] pidx;
   logic [DIST_W-1:0] ctr_cur, ctr_next;
   logic enc_emit, enc_we;
   logic [LEN_W-1:0] enc_len;
   logic [ENT_W-1:0] enc_data;
   logic [SZ_REC_W-1:0] sz_rec;

   assign cmt_ready = ord_free && sz_free;
   assign accept    = cmt_valid && cmt_ready;
   assign is_dma    = (cmt_agent == ID_W'(N_PROC));
   assign pidx      = cmt_agent[PIDX_W-1:0];

   clog_dist_counters #(.N_PROC(N_PROC), .DIST_W(DIST_W)) u_ctr (
      .clk  (clk),
      .rst_n(rst_n),
      .idx  (pidx),
      .cur  (ctr_cur),
      .we   (accept && !is_dma && enc_we),
      .wval (ctr_next)
   );

   clog_size_encoder #(.SIZE_W(SIZE_W), .DIST_W(DIST_W), .ENT_W(ENT_W), .LEN_W(LEN_W)) u_enc (
      .dist_mode(cfg_dist_mode),
      .trunc    (cmt_trunc),
      .count    (cmt_count),
      .ctr      (ctr_cur),
      .emit     (enc_emit),
      .len      (enc_len),
      .data     (enc_data),
      .ctr_we   (enc_we),
      .ctr_next (ctr_next)
   );

   clog_out_stage #(.W(ID_W)) u_ord (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept && !cfg_rr_order),
      .load_data(cmt_agent),
      .free     (ord_free),
      .out_valid(ord_valid),
      .out_ready(ord_ready),
      .out_data (ord_id)
   );

   clog_out_stage #(.W(SZ_REC_W)) u_sz (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept && !is_dma && enc_emit),
      .load_data({pidx, enc_len, enc_data}),
      .free     (sz_free),
      .out_valid(sz_valid),
      .out_ready(sz_ready),
      .out_data (sz_rec)
   );

   assign {sz_proc, sz_len, sz_data} = sz_rec;

   p_agent_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cmt_valid |-> (cmt_agent <= ID_W'(N_PROC)))
      else $error("agent number out of range");

   p_no_order_rr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && cfg_rr_order) |=> !ord_valid)
      else $error("order entry made in round-robin mode");

   p_dma_no_size_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && is_dma) |=> !sz_valid)
      else $error("size entry made for DMA commit");

   p_len_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
      sz_valid |-> (sz_len == LEN_W'(1) || sz_len == LEN_W'(SIZE_W + 1) || sz_len == LEN_W'(ENT_W)))
      else $error("illegal size entry length");

   p_stall_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ((ord_valid && !ord_ready) || (sz_valid && !sz_ready)) |-> !cmt_ready)
      else $error("commit taken while a stream stalls");

endmodule

// File: tb/tb_chunk_order_log.sv
module tb_chunk_order_log;

   localparam int CLK_PERIOD = 10;
   localparam int HALF   = CLK_PERIOD / 2;
   localparam int NP     = 8;
   localparam int IDW    = 4;
   localparam int SW     = 11;
   localparam int DW     = 4;
   localparam int EW     = SW + DW;
   localparam int LW     = $clog2(EW + 1);
   localparam int PW     = 3;
   localparam int DTOP   = (1 << DW) - 1;

   logic clk = 0, rst_n = 0;
   logic cfg_dist_mode = 0, cfg_rr_order = 0;
   logic cmt_valid = 0, cmt_ready, cmt_trunc = 0;
   logic [IDW-1:0] cmt_agent = '0;
   logic [SW-1:0]  cmt_count = '0;
   logic ord_valid, ord_ready = 0;
   logic [IDW-1:0] ord_id;
   logic sz_valid, sz_ready = 0;
   logic [PW-1:0] sz_proc;
   logic [LW-1:0] sz_len;
   logic [EW-1:0] sz_data;

   chunk_order_log #(.N_PROC(NP), .ID_W(IDW), .SIZE_W(SW), .DIST_W(DW)) dut (
      .clk(clk), .rst_n(rst_n),
      .cfg_dist_mode(cfg_dist_mode), .cfg_rr_order(cfg_rr_order),
      .cmt_valid(cmt_valid), .cmt_ready(cmt_ready),
      .cmt_agent(cmt_agent), .cmt_count(cmt_count), .cmt_trunc(cmt_trunc),
      .ord_valid(ord_valid), .ord_ready(ord_ready), .ord_id(ord_id),
      .sz_valid(sz_valid), .sz_ready(sz_ready), .sz_proc(sz_proc),
      .sz_len(sz_len), .sz_data(sz_data)
   );

   always #(HALF) clk = ~clk;

   int n_checks = 0, n_fail = 0;
   bit bp_on = 0;
   bit mon_on = 0;

   int    q_ord[$];
   int    q_sproc[$];
   int    q_slen[$];
   int    q_sdata[$];
   string q_stag[$];
   int    mctr[NP];

   task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (bp_on) begin
         ord_ready <= ($urandom % 3) != 0;
         sz_ready  <= ($urandom % 4) != 0;
      end else begin
         ord_ready <= 1'b1;
         sz_ready  <= 1'b1;
      end
   end

   // monitor and reference model, sampled one time unit before each rising edge
   initial begin
      forever begin
         @(negedge clk);
         #(HALF - 1);
         if (mon_on) begin
            // R10: commit path gated only by a stream that cannot drain
            check(cmt_ready == ((!ord_valid || ord_ready) && (!sz_valid || sz_ready)),
                  "R10", "cmt_ready", int'(cmt_ready), int'((!ord_valid || ord_ready) && (!sz_valid || sz_ready)));
            if (ord_valid && q_ord.size() == 0)
               check(0, "R2/R3", "unexpected order entry", int'(ord_id), -1);
            else if (ord_valid && ord_ready) begin
               int e;
               e = q_ord.pop_front();
               check(int'(ord_id) == e, "R2", "order id", int'(ord_id), e);
            end
            if (sz_valid && q_slen.size() == 0)
               check(0, "R6/R9", "unexpected size entry", int'(sz_data), -1);
            else if (sz_valid && sz_ready) begin
               int ep, el, ed;
               string tg;
               ep = q_sproc.pop_front();
               el = q_slen.pop_front();
               ed = q_sdata.pop_front();
               tg = q_stag.pop_front();
               check(int'(sz_proc) == ep, "R11", "size entry processor", int'(sz_proc), ep);
               check(int'(sz_len) == el, tg, "size entry length", int'(sz_len), el);
               check(int'(sz_data) == ed, tg, "size entry data", int'(sz_data), ed);
            end
            if (cmt_valid && cmt_ready) begin
               int a;
               a = int'(cmt_agent);
               if (!cfg_rr_order) q_ord.push_back(a);
               if (a != NP) begin
                  if (!cfg_dist_mode) begin
                     q_sproc.push_back(a);
                     if (cmt_trunc) begin
                        q_slen.push_back(SW + 1); q_sdata.push_back((1 << SW) + int'(cmt_count)); q_stag.push_back("R5");
                     end else begin
                        q_slen.push_back(1); q_sdata.push_back(0); q_stag.push_back("R4");
                     end
                  end else if (cmt_trunc) begin
                     q_sproc.push_back(a); q_slen.push_back(EW);
                     q_sdata.push_back(int'(cmt_count) * (1 << DW) + mctr[a]); q_stag.push_back("R7");
                     mctr[a] = 0;
                  end else begin
                     mctr[a] = mctr[a] + 1;
                     if (mctr[a] == DTOP) begin
                        q_sproc.push_back(a); q_slen.push_back(EW);
                        q_sdata.push_back(DTOP); q_stag.push_back("R8");
                        mctr[a] = 0;
                     end
                  end
               end
            end
         end
      end
   end

   task automatic commit(input int agent, input int count, input bit trunc);
      @(negedge clk);
      cmt_valid = 1; cmt_agent = IDW'(agent); cmt_count = SW'(count); cmt_trunc = trunc;
      forever begin
         #(HALF - 1);
         if (cmt_ready) break;
         @(negedge clk);
      end
   endtask

   task automatic idle(input int n);
      @(negedge clk);
      cmt_valid = 0;
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      check(0, "R10", "watchdog expired", 0, 1);
      finish_run();
   end

   initial begin
      for (int i = 0; i < NP; i++) mctr[i] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      #1;
      // R1: reset state
      check(!ord_valid, "R1", "ord_valid after reset", int'(ord_valid), 0);
      check(!sz_valid, "R1", "sz_valid after reset", int'(sz_valid), 0);
      check(cmt_ready, "R1", "cmt_ready after reset", int'(cmt_ready), 1);
      mon_on = 1;

      // per-chunk encoding, order stream on (R2 R4 R5 R9 R11)
      commit(0, 2000, 0);
      commit(1, 37, 1);
      commit(8, 0, 0);
      commit(0, 1999, 1);
      commit(7, 2000, 0);
      commit(2, 0, 1);
      idle(4);

      // distance encoding under back-pressure (R6 R7 R10)
      cfg_dist_mode = 1;
      bp_on = 1;
      for (int i = 0; i < 90; i++)
         commit(i % 9, (i % 5 == 2) ? (i * 37) % 2000 : 2000, i % 5 == 2);
      idle(10);

      // counter saturation on one processor (R8), others untouched (R7)
      bp_on = 0;
      idle(2);
      commit(3, 100, 1);
      for (int i = 0; i < 16; i++) commit(3, 2000, 0);
      commit(3, 500, 1);
      commit(4, 7, 1);
      idle(4);

      // round-robin order: no order entries (R3), mixed with DMA (R9)
      cfg_rr_order = 1;
      bp_on = 1;
      for (int i = 0; i < 30; i++)
         commit((i * 5) % 9, (i % 3 == 0) ? 1 + i * 11 : 2000, i % 3 == 0);
      idle(6);
      cfg_dist_mode = 0;
      for (int i = 0; i < 20; i++)
         commit((i * 7) % 9, (i % 2 == 1) ? i * 53 : 2000, i % 2 == 1);
      idle(6);

      // back to order logging with back-pressure (R2 R10)
      cfg_rr_order = 0;
      for (int i = 0; i < 40; i++)
         commit((i * 4) % 9, (i % 4 == 0) ? 1500 - i : 2000, i % 4 == 0);
      bp_on = 0;
      idle(20);

      check(q_ord.size() == 0, "R2", "order entries left undelivered", q_ord.size(), 0);
      check(q_slen.size() == 0, "R7", "size entries left undelivered", q_slen.size(), 0);
      finish_run();
   end

endmodule